// File: doc/BRIEF.md
# Keyed 64-bit Watchdog Timer

This block is a register-mapped 64-bit timer that only runs as a watchdog. Software loads a 64-bit timeout period as two 32-bit halves. It selects the watchdog timer mode and the continuous enable mode. It then arms the watchdog with an ordered pair of key writes. Once armed, the counter advances by one each clock. If software does not restart it in time, the block sets a timeout flag and drives a one-clock reset pulse to the rest of the chip.

Software restarts the counter by writing the same two keys in the same order. Any other non-zero key is taken as a sign of runaway code, and the block times out at once. From the first accepted key onward, the counter, period, timer control and global control registers are frozen. Only the block's own reset input disarms it.

Top module: `keyed_wdog`

## Requirements
- R1: After reset, the counter, the period, the timer control, the global control, the enable bit and the flag all read zero, and `wdReset` is low. Offset 0x00 reads the parameter `ID_VALUE` (default 0x00014C57). Offset 0x04 and unmapped offsets read zero.
- R2: While unarmed, writes take effect and read back as follows. Timer control at 0x20 keeps bits 7:6, which form the enable mode (2 = continuous). Global control at 0x24 keeps bits 3:0: bit 0 and bit 1 are the half reset-release bits, and bits 3:2 are the mode (2 = 64-bit watchdog). Unused bits read zero.
- R3: The watchdog control register sits at 0x28, with the key in bits 31:16, the enable in bit 14 and the flag in bit 15. The block arms in two steps. First, a write of key 0xA5C6 with bit 14 set moves it to a pre-active stage, but only while the mode is 2 and the enable mode is 2. Next, a write of key 0xDA7E with bit 14 set makes it active.
- R4: From the pre-active stage onward, writes to the counter (0x10 low, 0x14 high), the period (0x18 low, 0x1C high), the timer control and the global control have no effect.
- R5: The 64-bit counter advances by one each clock only while active, carrying from the low half into the high half. It holds its value otherwise. Reads of 0x10 and 0x14 return its live value.
- R6: While active, when the counter equals the period, the flag is set and `wdReset` is high for exactly the one clock after that edge. The counter then restarts from zero. With the counter at 0 when the watchdog becomes active, the pulse is seen at the (period+1)-th clock edge after that point.
- R7: While active, key 0xA5C6 enters a service stage in which counting continues. A following key 0xDA7E clears the counter to zero and returns to active.
- R8: While active or in service, a write at 0x28 whose key is non-zero and is not the key expected next causes an immediate timeout. The flag is set, `wdReset` pulses in the clock after the write, and the counter restarts at zero. A key of zero is not a key write and causes no timeout.
- R9: Software can set the enable bit but cannot clear it. Writing 1 to bit 15 clears the flag. A read of 0x28 returns only the enable and the flag, with zeros in the key field.
- R10: A key pair written while the mode is not 2 or the enable mode is not 2 does not arm the block. The counter stays still and the period stays writable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low reset; the only way to disarm |
| busAddr | input | ADDR_W (8) | Register byte offset |
| busWe | input | 1 | Write strobe, one write per clock |
| busWrData | input | 32 | Write data |
| busRdData | output | 32 | Read data for `busAddr`, combinational |
| wdReset | output | 1 | One-clock timeout reset pulse |

## Verification
The hardest state to reach is a 64-bit counter near its carry or its period, because counting there from zero would take far too long. The stimulus loads the counter halves directly before arming, with the low half just below its wrap, so the carry shows up within a few clocks. Short periods are used to time the timeout pulse to the exact clock edge. Wrong keys and key-zero flag clears are injected mid-period to separate the immediate timeout from a plain write.

// File: rtl/wdog_pkg.sv
package wdog_pkg;
  typedef enum logic [1:0] {
    WS_IDLE    = 2'd0,
    WS_PREACT  = 2'd1,
    WS_ACTIVE  = 2'd2,
    WS_SERVICE = 2'd3
  } wdState_t;

  typedef struct packed {
    logic cntLoLd;
    logic cntHiLd;
    logic prdLoLd;
    logic prdHiLd;
    logic cntClr;
    logic run;
  } dpStrobe_t;

  localparam logic [15:0] KEY_FIRST  = 16'hA5C6;
  localparam logic [15:0] KEY_SECOND = 16'hDA7E;
  localparam logic [1:0]  MODE_WDOG  = 2'd2;
  localparam logic [1:0]  ENA_CONT   = 2'd2;
endpackage

// File: rtl/wdog_dpath.sv
module wdog_dpath
  import wdog_pkg::*;
#(
  parameter int HALF_W = 32
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  dpStrobe_t             strb,
  input  logic [HALF_W-1:0]     wrData,
  output logic [2*HALF_W-1:0]   cnt,
  output logic [2*HALF_W-1:0]   prd,
  output logic                  hit
);
  localparam int CNT_W = 2 * HALF_W;

  logic [1:0] prdLd;
  assign prdLd = {strb.prdHiLd, strb.prdLoLd};

  assign hit = strb.run && (cnt == prd);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cnt <= '0;
    end else if (strb.cntClr || hit) begin
      cnt <= '0;
    end else if (strb.run) begin
      cnt <= cnt + CNT_W'(1);
    end else begin
      if (strb.cntLoLd) cnt[HALF_W-1:0]     <= wrData;
      if (strb.cntHiLd) cnt[CNT_W-1:HALF_W] <= wrData;
    end
  end

  for (genvar h = 0; h < 2; h++) begin : gPrdHalf
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) prd[h*HALF_W +: HALF_W] <= '0;
      else if (prdLd[h]) prd[h*HALF_W +: HALF_W] <= wrData;
    end
  end

  AST_CNT_STEP: assert property (@(posedge clk) disable iff (!rstN)
    (strb.run && !strb.cntClr && !hit) |=> (cnt == $past(cnt) + CNT_W'(1))); // R5
  AST_CNT_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (!strb.run && !strb.cntClr && !strb.cntLoLd && !strb.cntHiLd) |=> $stable(cnt)); // R5
  AST_HIT_RESTART: assert property (@(posedge clk) disable iff (!rstN)
    hit |=> (cnt == '0)); // R6
endmodule

// File: rtl/wdog_ctrl.sv
module wdog_ctrl
  import wdog_pkg::*;
#(
  parameter int          ADDR_W   = 8,
  parameter int          HALF_W   = 32,
  parameter logic [31:0] ID_VALUE = 32'h0001_4C57
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic [ADDR_W-1:0]   addr,
  input  logic                we,
  input  logic [HALF_W-1:0]   wrData,
  input  logic [2*HALF_W-1:0] cnt,
  input  logic [2*HALF_W-1:0] prd,
  input  logic                hit,
  output dpStrobe_t           strb,
  output logic [HALF_W-1:0]   rdData,
  output logic                wdReset
);
  localparam int CNT_W = 2 * HALF_W;
  localparam logic [ADDR_W-1:0] A_ID    = ADDR_W'('h00);
  localparam logic [ADDR_W-1:0] A_EMU   = ADDR_W'('h04);
  localparam logic [ADDR_W-1:0] A_CNTLO = ADDR_W'('h10);
  localparam logic [ADDR_W-1:0] A_CNTHI = ADDR_W'('h14);
  localparam logic [ADDR_W-1:0] A_PRDLO = ADDR_W'('h18);
  localparam logic [ADDR_W-1:0] A_PRDHI = ADDR_W'('h1C);
  localparam logic [ADDR_W-1:0] A_TCTL  = ADDR_W'('h20);
  localparam logic [ADDR_W-1:0] A_GCTL  = ADDR_W'('h24);
  localparam logic [ADDR_W-1:0] A_WCTL  = ADDR_W'('h28);

  wdState_t    state, stateNxt;
  logic [1:0]  enaMode;
  logic [3:0]  gcrReg;
  logic        wdEn, wdFlag;
  logic        locked, armed, wrWd, keyFail, timeout;
  logic [15:0] key;
  logic        unusedBits;

  assign unusedBits = ^{wrData[13:8], wrData[5:4]};
  assign key    = wrData[31:16];
  assign wrWd   = we && (addr == A_WCTL);
  assign locked = (state != WS_IDLE);
  assign armed  = (state == WS_ACTIVE) || (state == WS_SERVICE);

  always_comb begin
    stateNxt = state;
    keyFail  = 1'b0;
    strb     = '0;
    strb.run = armed;
    unique case (state)
      WS_IDLE: begin
        if (wrWd && key == KEY_FIRST && wrData[14] &&
            gcrReg[3:2] == MODE_WDOG && enaMode == ENA_CONT)
          stateNxt = WS_PREACT;
      end
      WS_PREACT: begin
        if (wrWd && key == KEY_SECOND && wrData[14]) stateNxt = WS_ACTIVE;
      end
      WS_ACTIVE: begin
        if (wrWd && key == KEY_FIRST) stateNxt = WS_SERVICE;
        else if (wrWd && key != 16'h0) keyFail = 1'b1;
      end
      WS_SERVICE: begin
        if (wrWd && key == KEY_SECOND) begin
          stateNxt    = WS_ACTIVE;
          strb.cntClr = 1'b1;
        end else if (wrWd && key != 16'h0) begin
          keyFail  = 1'b1;
          stateNxt = WS_ACTIVE;
        end
      end
      default: stateNxt = WS_IDLE;
    endcase
    if (keyFail) strb.cntClr = 1'b1;
    strb.cntLoLd = we && !locked && (addr == A_CNTLO);
    strb.cntHiLd = we && !locked && (addr == A_CNTHI);
    strb.prdLoLd = we && !locked && (addr == A_PRDLO);
    strb.prdHiLd = we && !locked && (addr == A_PRDHI);
  end

  assign timeout = hit || keyFail;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= WS_IDLE;
      enaMode <= '0;
      gcrReg  <= '0;
      wdEn    <= 1'b0;
      wdFlag  <= 1'b0;
      wdReset <= 1'b0;
    end else begin
      state   <= stateNxt;
      wdReset <= timeout;
      if (we && !locked && addr == A_TCTL) enaMode <= wrData[7:6];
      if (we && !locked && addr == A_GCTL) gcrReg  <= wrData[3:0];
      if (wrWd && !locked && wrData[14]) wdEn <= 1'b1;
      if (timeout) wdFlag <= 1'b1;
      else if (wrWd && wrData[15]) wdFlag <= 1'b0;
    end
  end

  always_comb begin
    rdData = '0;
    case (addr)
      A_ID:    rdData = ID_VALUE;
      A_EMU:   rdData = '0;
      A_CNTLO: rdData = cnt[HALF_W-1:0];
      A_CNTHI: rdData = cnt[CNT_W-1:HALF_W];
      A_PRDLO: rdData = prd[HALF_W-1:0];
      A_PRDHI: rdData = prd[CNT_W-1:HALF_W];
      A_TCTL:  rdData[7:6] = enaMode;
      A_GCTL:  rdData[3:0] = gcrReg;
      A_WCTL:  begin
        rdData[15] = wdFlag;
        rdData[14] = wdEn;
      end
      default: rdData = '0;
    endcase
  end

  AST_LOCK_CFG: assert property (@(posedge clk) disable iff (!rstN)
    locked |=> ($stable(enaMode) && $stable(gcrReg))); // R4
  AST_ARMED_EN: assert property (@(posedge clk) disable iff (!rstN)
    locked |-> wdEn); // R3
  AST_EN_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    wdEn |=> wdEn); // R9
  AST_FLAG_WITH_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    wdReset |-> wdFlag); // R6
  AST_KEY_FAIL: assert property (@(posedge clk) disable iff (!rstN)
    (state == WS_ACTIVE && wrWd && key != 16'h0 && key != KEY_FIRST) |=> wdReset); // R8
endmodule

// File: rtl/keyed_wdog.sv
module keyed_wdog
  import wdog_pkg::*;
#(
  parameter int          ADDR_W   = 8,
  parameter logic [31:0] ID_VALUE = 32'h0001_4C57
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWe,
  input  logic [31:0]       busWrData,
  output logic [31:0]       busRdData,
  output logic              wdReset
);
  localparam int HALF_W = 32;

  dpStrobe_t             strb;
  logic [2*HALF_W-1:0]   cnt, prd;
  logic                  hit;

  wdog_ctrl #(.ADDR_W(ADDR_W), .HALF_W(HALF_W), .ID_VALUE(ID_VALUE)) uCtrl (
    .clk(clk), .rstN(rstN), .addr(busAddr), .we(busWe), .wrData(busWrData),
    .cnt(cnt), .prd(prd), .hit(hit), .strb(strb), .rdData(busRdData),
    .wdReset(wdReset)
  );

  wdog_dpath #(.HALF_W(HALF_W)) uDpath (
    .clk(clk), .rstN(rstN), .strb(strb), .wrData(busWrData),
    .cnt(cnt), .prd(prd), .hit(hit)
  );
endmodule

// File: tb/keyed_wdog_test.sv
module keyed_wdog_test;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [7:0]  busAddr = '0;
  logic        busWe = 1'b0;
  logic [31:0] busWrData = '0;
  logic [31:0] busRdData;
  logic        wdReset;
  int          nChk = 0;
  int          nErr = 0;

  localparam logic [31:0] ID = 32'h0001_4C57;

  keyed_wdog uut (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWe(busWe),
    .busWrData(busWrData), .busRdData(busRdData), .wdReset(wdReset)
  );

  always #5 clk = ~clk;

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nChk++;
    if (act !== exp) begin
      nErr++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic doReset();
    rstN = 1'b0; busWe = 1'b0;
    repeat (2) @(posedge clk);
    #1 rstN = 1'b1;
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    busAddr = a; busWrData = d; busWe = 1'b1;
    @(posedge clk);
    #1 busWe = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    busAddr = a;
    #1 d = busRdData;
  endtask

  task automatic arm(input logic [31:0] c0, input logic [31:0] pLo, input logic [31:0] pHi);
    wr(8'h10, c0); wr(8'h14, 32'h0);
    wr(8'h18, pLo); wr(8'h1C, pHi);
    wr(8'h20, 32'h80); wr(8'h24, 32'hB);
    wr(8'h28, 32'hA5C6_4000); wr(8'h28, 32'hDA7E_4000);
  endtask

  task automatic edgesToPulse(output int k);
    k = 0;
    for (int i = 1; i <= 64; i++) begin
      @(posedge clk); #1;
      if (wdReset && k == 0) k = i;
      if (k != 0) break;
    end
  endtask

  task automatic tReset();
    logic [31:0] d;
    doReset();
    rd(8'h00, d); check("R1 id", d, ID);
    rd(8'h04, d); check("R1 emu", d, 0);
    rd(8'h10, d); check("R1 cntlo", d, 0);
    rd(8'h18, d); check("R1 prdlo", d, 0);
    rd(8'h20, d); check("R1 tctl", d, 0);
    rd(8'h28, d); check("R1 wctl", d, 0);
    check("R1 pulse", {31'b0, wdReset}, 0);
  endtask

  task automatic tRegs();
    logic [31:0] d;
    doReset();
    wr(8'h20, 32'hFFFF_FFFF); rd(8'h20, d); check("R2 tctl mask", d, 32'hC0);
    wr(8'h24, 32'hFFFF_FFFF); rd(8'h24, d); check("R2 gctl mask", d, 32'hF);
    wr(8'h1C, 32'h1234_5678); rd(8'h1C, d); check("R2 prdhi", d, 32'h1234_5678);
  endtask

  task automatic tTimeout();
    logic [31:0] d; int k;
    doReset();
    arm(0, 5, 0);
    rd(8'h10, d); check("R5 cnt at arm", d, 0);
    edgesToPulse(k); check("R6 pulse edge", k, 6);
    rd(8'h28, d); check("R9 wctl read", d, 32'hC000);
    @(posedge clk); #1;
    check("R6 one clock", {31'b0, wdReset}, 0);
    rd(8'h10, d); check("R6 restart", d, 1);
  endtask

  task automatic tService();
    logic [31:0] d; int k;
    doReset();
    arm(0, 20, 0);
    repeat (10) @(posedge clk);
    #1;
    wr(8'h28, 32'hA5C6_0000);
    rd(8'h10, d); check("R7 counts in service", d, 11);
    wr(8'h28, 32'hDA7E_0000);
    rd(8'h10, d); check("R7 cleared", d, 0);
    edgesToPulse(k); check("R7 period after service", k, 21);
  endtask

  task automatic tWrongKey();
    logic [31:0] d;
    doReset();
    arm(0, 100, 0);
    repeat (4) @(posedge clk);
    #1;
    wr(8'h28, 32'h1234_0000);
    check("R8 immediate pulse", {31'b0, wdReset}, 1);
    rd(8'h10, d); check("R8 cnt restart", d, 0);
    wr(8'h28, 32'h0000_8000);
    check("R8 key zero no pulse", {31'b0, wdReset}, 0);
    rd(8'h28, d); check("R9 flag cleared", d, 32'h4000);
    wr(8'h28, 32'h0000_0000);
    rd(8'h28, d); check("R9 enable sticky", d, 32'h4000);
  endtask

  task automatic tLock();
    logic [31:0] d;
    doReset();
    wr(8'h18, 50); wr(8'h20, 32'h80); wr(8'h24, 32'hB);
    wr(8'h28, 32'hA5C6_4000);
    wr(8'h18, 7);     rd(8'h18, d); check("R4 prdlo locked", d, 50);
    wr(8'h20, 0);     rd(8'h20, d); check("R4 tctl locked", d, 32'h80);
    wr(8'h24, 0);     rd(8'h24, d); check("R4 gctl locked", d, 32'hB);
    wr(8'h10, 32'h99); rd(8'h10, d); check("R4 cnt locked", d, 0);
    wr(8'h28, 32'hDA7E_4000);
    wr(8'h1C, 5);     rd(8'h1C, d); check("R4 prdhi locked active", d, 0);
    rd(8'h10, d); check("R3 active counting", d, 1);
  endtask

  task automatic tNoArm();
    logic [31:0] d;
    doReset();
    wr(8'h20, 32'h80); wr(8'h24, 32'h3);
    wr(8'h28, 32'hA5C6_4000); wr(8'h28, 32'hDA7E_4000);
    repeat (5) @(posedge clk);
    #1;
    rd(8'h10, d); check("R10 no count", d, 0);
    wr(8'h18, 9); rd(8'h18, d); check("R10 still writable", d, 9);
  endtask

  task automatic tCarry();
    logic [31:0] d;
    doReset();
    arm(32'hFFFF_FFFE, 0, 2);
    repeat (3) @(posedge clk);
    #1;
    rd(8'h14, d); check("R5 carry hi", d, 1);
    rd(8'h10, d); check("R5 carry lo", d, 1);
  endtask

  initial begin
    tReset();
    tRegs();
    tTimeout();
    tService();
    tWrongKey();
    tLock();
    tNoArm();
    tCarry();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChk, nErr);
    $finish;
  end

  initial begin
    #1000000;
    nChk++; nErr++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChk, nErr);
    $finish;
  end
endmodule